// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits beside the page-load path of a byte-wide non-volatile memory. It watches the stream of bus write events, each an address and a data byte. Some fixed multi-write command sequences arm or release a protection flag, and the block watches for them. For every write event it reports one cycle later whether the byte may go into the page buffer to be programmed, or whether it was taken as a command byte. A load is the group of writes between two expiries of the byte-load window, which a separate timer signals. Protection changes only when a load closes.

A load that opens with the three-write key (AAh to 5555h, 55h to 2AAAh, A0h to 5555h) may carry data even while protected, and it arms protection when it closes. A load that opens with the six-write release sequence clears protection when it closes. In the protected state, any other load is thrown away. The reset value of the flag is a parameter. It stands in for the value kept across power cycles, and the default is unprotected. Page bits are the address bits above the in-page offset: bits 14:6 by default.

Top module: `wr_protect_seq`

## Requirements
- R1: On reset, protect_o equals the INIT_PROTECT parameter, and wr_commit_o and cmd_byte_o are 0.
- R2: Each write of a recognised command step gives cmd_byte_o = 1 and wr_commit_o = 0 in the cycle after the write. The step patterns, counted from the first write of a load, are AAh@5555h, 55h@2AAAh, then either A0h@5555h (key complete), or 80h@5555h followed by AAh@5555h, 55h@2AAAh and 20h@5555h (release complete).
- R3: After a complete key, the data writes of the same load give wr_commit_o = 1. protect_o becomes 1 in the cycle after the load's window expiry.
- R4: In the protected state, a load that opens with the key commits its data, and protect_o stays 1 after it closes.
- R5: In the protected state, a load whose first write is not AAh@5555h, or that departs from the sequence at any step, commits none of its bytes. protect_o stays 1.
- R6: After a complete release sequence, the remaining writes of that load give neither pulse. protect_o becomes 0 in the cycle after the window expiry.
- R7: In the unprotected state, every data byte gives wr_commit_o = 1. A write that breaks a partial sequence is committed. The command bytes before it are not committed.
- R8: Within a load, a data byte whose page bits differ from those of the load's first data byte is not committed, and neither is any later byte of that load.
- R9: When the window expires mid-sequence, the sequencer returns to idle without changing protection. The next write starts a new load.
- R10: protect_o changes only in the cycle after a window expiry.
- R11: A write in the same cycle as an expiry is the first write of the new load. It is judged against the protection value that the closing load leaves behind.
- R12: Sequences are recognised only at the start of a load. A command pattern written later in a data load is handled as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | A write event is present this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| load_expire_i | input | 1 | Byte-load window expired: the current load closes |
| protect_o | output | 1 | Protection flag |
| wr_commit_o | output | 1 | Pulse: the previous cycle's write byte goes to the page buffer |
| cmd_byte_o | output | 1 | Pulse: the previous cycle's write byte was consumed as a command |

## Verification
The hardest state to reach is a write that arrives in the very cycle its load closes. For a correct result, the pending arm or release must reach that write before the flag register has moved. The stimulus ends a release load by raising the expiry and a write together, then checks that the write is committed as unprotected. Exhaustive sweeps cover two more cases. One sends every data value at the first key address in the protected state, where only AAh may act. The other sends every offset of one page, followed by a foreign page, in a single load.

// File: rtl/wr_protect_seq_pkg.sv
package wr_protect_seq_pkg;

   localparam int unsigned STEP_W    = 3;
   localparam int unsigned SEQ_STEPS = 6;
   localparam int unsigned ENA_STEP  = 2;
   localparam logic [7:0]  ENA_CODE  = 8'hA0;

   typedef enum logic [1:0] {
      LD_IDLE,
      LD_SEQ,
      LD_DATA,
      LD_DROP
   } ld_mode_e;

   typedef struct packed {
      logic              hit;
      logic              en_done;
      logic              dis_done;
      logic [STEP_W-1:0] nxt;
   } match_t;

   // data byte expected at each step of the release path
   function automatic logic [7:0] step_code(input int unsigned s);
      case (s)
         0:       return 8'hAA;
         1:       return 8'h55;
         2:       return 8'h80;
         3:       return 8'hAA;
         4:       return 8'h55;
         default: return 8'h20;
      endcase
   endfunction

   // 1 when a step targets the first command address, 0 for the second
   function automatic logic step_on_a(input int unsigned s);
      return !(s == 1 || s == 4);
   endfunction

endpackage

// File: rtl/wr_protect_seq_match.sv
module wr_protect_seq_match
   import wr_protect_seq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CMD_ADDR_A = 'h5555,
   parameter int unsigned CMD_ADDR_B = 'h2AAA
) (
   input  logic [STEP_W-1:0] step_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output match_t            match_o
);

   localparam int unsigned SLOTS = 1 << STEP_W;

   logic             at_a;
   logic             at_b;
   logic             ena_hit;
   logic [SLOTS-1:0] step_hit;

   assign at_a    = (addr_i == ADDR_W'(CMD_ADDR_A));
   assign at_b    = (addr_i == ADDR_W'(CMD_ADDR_B));
   assign ena_hit = at_a && (data_i == DATA_W'(ENA_CODE));

   for (genvar s = 0; s < SLOTS; s++) begin : g_step
      if (s < SEQ_STEPS) begin : g_live
         assign step_hit[s] = (step_on_a(s) ? at_a : at_b) &&
                              (data_i == DATA_W'(step_code(s)));
      end else begin : g_pad
         assign step_hit[s] = 1'b0;
      end
   end

   // R2: the key branch leaves the release path at the third step
   always_comb begin
      match_o = '0;
      if (step_i == STEP_W'(ENA_STEP) && ena_hit) begin
         match_o.hit     = 1'b1;
         match_o.en_done = 1'b1;
      end else if (step_hit[step_i]) begin
         match_o.hit = 1'b1;
         if (step_i == STEP_W'(SEQ_STEPS - 1)) begin
            match_o.dis_done = 1'b1;
         end else begin
            match_o.nxt = step_i + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wr_protect_seq_page.sv
module wr_protect_seq_page #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned PAGE_OFS_W = 6,
   parameter bit          ENABLE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              latch_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ok_o
);

   localparam int unsigned PAGE_W = ADDR_W - PAGE_OFS_W;

   logic unused_ofs;
   assign unused_ofs = ^addr_i[PAGE_OFS_W-1:0];

   if (ENABLE) begin : g_check
      logic [PAGE_W-1:0] page_q;
      logic              held_q;
      logic [PAGE_W-1:0] page_w;

      assign page_w = addr_i[ADDR_W-1:PAGE_OFS_W];
      // R8: first data byte of a load fixes the page
      assign ok_o   = !held_q || (page_w == page_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            page_q <= '0;
            held_q <= 1'b0;
         end else if (latch_i) begin
            page_q <= page_w;
            held_q <= 1'b1;
         end else if (clear_i) begin
            held_q <= 1'b0;
         end
      end
   end else begin : g_free
      logic unused_in;
      assign unused_in = ^{clk, rst_n, clear_i, latch_i, addr_i};
      assign ok_o      = 1'b1;
   end

endmodule

// File: rtl/wr_protect_seq_flag.sv
module wr_protect_seq_flag #(
   parameter bit INIT_PROTECT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic prot_o
);

   // R1 / R10: reset to the stored value, move only on a closing load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_o <= INIT_PROTECT;
      end else if (set_i) begin
         prot_o <= 1'b1;
      end else if (clr_i) begin
         prot_o <= 1'b0;
      end
   end

endmodule

// File: rtl/wr_protect_seq.sv
module wr_protect_seq
   import wr_protect_seq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 15,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PAGE_OFS_W   = 6,
   parameter int unsigned CMD_ADDR_A   = 'h5555,
   parameter int unsigned CMD_ADDR_B   = 'h2AAA,
   parameter bit          INIT_PROTECT = 1'b0,
   parameter bit          PAGE_CHECK   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              load_expire_i,
   output logic              protect_o,
   output logic              wr_commit_o,
   output logic              cmd_byte_o
);

   initial begin
      assert (ADDR_W > PAGE_OFS_W && PAGE_OFS_W >= 1)
         else $error("page offset must be narrower than the address");
      assert (DATA_W >= 8)
         else $error("command codes need at least 8 data bits");
      assert (CMD_ADDR_A < (1 << ADDR_W) && CMD_ADDR_B < (1 << ADDR_W))
         else $error("command addresses exceed the address width");
      assert (CMD_ADDR_A != CMD_ADDR_B)
         else $error("command addresses must differ");
   end

   ld_mode_e          mode_q, mode_n, mode_cur;
   logic [STEP_W-1:0] step_q, step_n, step_use;
   logic              pend_set_q, pend_set_n;
   logic              pend_clr_q, pend_clr_n;
   logic              commit_n, cmd_n;
   logic              commit_q, cmd_q;
   logic              fresh;
   logic              prot_eff;
   logic              page_ok;
   match_t            hit;

   // R11: a write coincident with expiry opens the next load
   assign fresh    = (mode_q == LD_IDLE) || load_expire_i;
   assign mode_cur = fresh ? LD_SEQ : mode_q;
   assign step_use = fresh ? '0 : step_q;
   assign prot_eff = load_expire_i ? (pend_set_q | (protect_o & ~pend_clr_q))
                                   : protect_o;

   wr_protect_seq_match #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CMD_ADDR_A (CMD_ADDR_A),
      .CMD_ADDR_B (CMD_ADDR_B)
   ) match_i (
      .step_i  (step_use),
      .addr_i  (wr_addr_i),
      .data_i  (wr_data_i),
      .match_o (hit)
   );

   wr_protect_seq_page #(
      .ADDR_W     (ADDR_W),
      .PAGE_OFS_W (PAGE_OFS_W),
      .ENABLE     (PAGE_CHECK)
   ) page_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (load_expire_i),
      .latch_i (commit_n),
      .addr_i  (wr_addr_i),
      .ok_o    (page_ok)
   );

   wr_protect_seq_flag #(
      .INIT_PROTECT (INIT_PROTECT)
   ) flag_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (load_expire_i & pend_set_q),
      .clr_i  (load_expire_i & pend_clr_q),
      .prot_o (protect_o)
   );

   always_comb begin
      mode_n     = mode_q;
      step_n     = step_q;
      pend_set_n = pend_set_q;
      pend_clr_n = pend_clr_q;
      commit_n   = 1'b0;
      cmd_n      = 1'b0;
      // R9: expiry returns the sequencer to idle
      if (load_expire_i) begin
         mode_n     = LD_IDLE;
         step_n     = '0;
         pend_set_n = 1'b0;
         pend_clr_n = 1'b0;
      end
      if (wr_valid_i) begin
         case (mode_cur)
            LD_SEQ: begin
               if (hit.hit) begin
                  cmd_n  = 1'b1;
                  step_n = hit.nxt;
                  if (hit.en_done) begin
                     pend_set_n = 1'b1;       // R3 / R4
                     mode_n     = LD_DATA;
                  end else if (hit.dis_done) begin
                     pend_clr_n = 1'b1;       // R6
                     mode_n     = LD_DROP;
                  end else begin
                     mode_n = LD_SEQ;
                  end
               end else if (prot_eff) begin
                  mode_n = LD_DROP;           // R5
                  step_n = '0;
               end else begin
                  mode_n   = LD_DATA;         // R7
                  step_n   = '0;
                  commit_n = 1'b1;
               end
            end
            LD_DATA: begin
               if (page_ok) begin
                  commit_n = 1'b1;            // R12: no matching here
               end else begin
                  mode_n = LD_DROP;           // R8
               end
            end
            default: begin
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= LD_IDLE;
         step_q     <= '0;
         pend_set_q <= 1'b0;
         pend_clr_q <= 1'b0;
         commit_q   <= 1'b0;
         cmd_q      <= 1'b0;
      end else begin
         mode_q     <= mode_n;
         step_q     <= step_n;
         pend_set_q <= pend_set_n;
         pend_clr_q <= pend_clr_n;
         commit_q   <= commit_n;
         cmd_q      <= cmd_n;
      end
   end

   assign wr_commit_o = commit_q;
   assign cmd_byte_o  = cmd_q;

endmodule

// File: rtl/wr_protect_seq_chk.sv
module wr_protect_seq_chk #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned CMD_ADDR_A = 'h5555,
   parameter int unsigned CMD_ADDR_B = 'h2AAA
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic              load_expire_i,
   input logic              protect_o,
   input logic              wr_commit_o,
   input logic              cmd_byte_o,
   input logic              pend_set_q,
   input logic              pend_clr_q
);

   p_one_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_commit_o && cmd_byte_o));

   p_pulse_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit_o || cmd_byte_o) |-> $past(wr_valid_i));

   p_cmd_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_byte_o |-> ($past(wr_addr_i) == ADDR_W'(CMD_ADDR_A) ||
                      $past(wr_addr_i) == ADDR_W'(CMD_ADDR_B)));

   p_prot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load_expire_i |=> $stable(protect_o));

   p_prot_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_expire_i && !pend_set_q) |=> !$rose(protect_o));

   p_prot_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_expire_i && !pend_clr_q) |=> !$fell(protect_o));

endmodule

bind wr_protect_seq wr_protect_seq_chk #(
   .ADDR_W     (ADDR_W),
   .CMD_ADDR_A (CMD_ADDR_A),
   .CMD_ADDR_B (CMD_ADDR_B)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_valid_i    (wr_valid_i),
   .wr_addr_i     (wr_addr_i),
   .load_expire_i (load_expire_i),
   .protect_o     (protect_o),
   .wr_commit_o   (wr_commit_o),
   .cmd_byte_o    (cmd_byte_o),
   .pend_set_q    (pend_set_q),
   .pend_clr_q    (pend_clr_q)
);

// File: tb/wr_protect_seq_tb_top.sv
`timescale 1ns/1ps
module wr_protect_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [14:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        load_expire = 1'b0;
   logic        protect, commit, cmd;
   logic        p_protect, p_commit, p_cmd;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   wr_protect_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .load_expire_i(load_expire),
      .protect_o(protect), .wr_commit_o(commit), .cmd_byte_o(cmd)
   );

   wr_protect_seq #(.INIT_PROTECT(1'b1)) dut_p_i (
      .clk(clk), .rst_n(rst_n), .wr_valid_i(1'b0), .wr_addr_i(15'h0),
      .wr_data_i(8'h0), .load_expire_i(1'b0),
      .protect_o(p_protect), .wr_commit_o(p_commit), .cmd_byte_o(p_cmd)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [14:0] a, input logic [7:0] d,
                     input int ec, input int ek, input string tag);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      chk(tag, "commit", int'(commit), ec);
      chk(tag, "cmd", int'(cmd), ek);
   endtask

   task automatic expire(input int ep, input string tag);
      @(negedge clk);
      load_expire = 1'b1;
      @(negedge clk);
      load_expire = 1'b0;
      chk(tag, "protect", int'(protect), ep);
   endtask

   task automatic key(input string tag);
      wr(15'h5555, 8'hAA, 0, 1, tag);
      wr(15'h2AAA, 8'h55, 0, 1, tag);
      wr(15'h5555, 8'hA0, 0, 1, tag);
   endtask

   task automatic unkey(input string tag);
      wr(15'h5555, 8'hAA, 0, 1, tag);
      wr(15'h2AAA, 8'h55, 0, 1, tag);
      wr(15'h5555, 8'h80, 0, 1, tag);
      wr(15'h5555, 8'hAA, 0, 1, tag);
      wr(15'h2AAA, 8'h55, 0, 1, tag);
      wr(15'h5555, 8'h20, 0, 1, tag);
   endtask

   initial begin
      #1000000;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state for both stored values
      chk("R1", "protect", int'(protect), 0);
      chk("R1", "commit", int'(commit), 0);
      chk("R1", "cmd", int'(cmd), 0);
      chk("R1", "protect_init1", int'(p_protect), 1);
      chk("R1", "pulses_init1", int'(p_commit | p_cmd), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "protect_after_release", int'(protect), 0);

      // R7 / R8: unprotected page sweep, page = addr >> 6
      for (int o = 0; o < 64; o++) begin
         wr(15'h0100 + 15'(o), 8'(o), 1, 0, "R7_sweep");
      end
      wr(15'h0140, 8'h11, 0, 0, "R8_foreign_page");
      wr(15'h0100, 8'h22, 0, 0, "R8_after_drop");
      expire(0, "R10_unprot_stays");

      // R7: broken partial sequence
      wr(15'h5555, 8'hAA, 0, 1, "R7");
      wr(15'h0200, 8'h12, 1, 0, "R7_breaker");
      wr(15'h0201, 8'h13, 1, 0, "R7");
      expire(0, "R7");

      // R12: pattern in the middle of a data load (same page 0x155)
      wr(15'h5540, 8'h01, 1, 0, "R12");
      wr(15'h5555, 8'hAA, 1, 0, "R12_pattern_as_data");
      expire(0, "R12");

      // R9: expiry in the middle of the key
      wr(15'h5555, 8'hAA, 0, 1, "R9");
      wr(15'h2AAA, 8'h55, 0, 1, "R9");
      expire(0, "R9_no_change");
      wr(15'h5555, 8'hA0, 1, 0, "R9_fresh_load");
      expire(0, "R9");

      // R2 / R3: key with data while unprotected
      key("R2");
      for (int i = 0; i < 4; i++) begin
         wr(15'h0300 + 15'(i), 8'h40 + 8'(i), 1, 0, "R3_data");
      end
      chk("R10", "protect_before_expire", int'(protect), 0);
      expire(1, "R3_set");

      // R5: protected, every first-byte value at the first key address
      for (int d = 0; d < 256; d++) begin
         wr(15'h5555, 8'(d), 0, (d == 'hAA) ? 1 : 0, "R5_sweep");
         wr(15'h0300, 8'h11, 0, 0, "R5_follow");
         expire(1, "R5_sweep");
      end

      // R5: departing at the third step
      wr(15'h5555, 8'hAA, 0, 1, "R5");
      wr(15'h2AAA, 8'h55, 0, 1, "R5");
      wr(15'h5555, 8'h33, 0, 0, "R5_depart");
      wr(15'h0300, 8'h44, 0, 0, "R5_drop");
      expire(1, "R5");

      // R4: keyed write while protected, with a page violation (R8)
      key("R4");
      wr(15'h0400, 8'h55, 1, 0, "R4_data");
      wr(15'h0401, 8'h66, 1, 0, "R4_data");
      wr(15'h0440, 8'h77, 0, 0, "R8_after_key");
      wr(15'h0402, 8'h88, 0, 0, "R8_after_key");
      expire(1, "R4_stays");

      // R6: release sequence
      unkey("R6");
      wr(15'h0500, 8'h99, 0, 0, "R6_ignored");
      chk("R10", "protect_before_expire", int'(protect), 1);
      expire(0, "R6_clear");

      // R11: write coincident with the expiry of a release load
      key("R11");
      expire(1, "R11_setup");
      unkey("R11");
      @(negedge clk);
      load_expire = 1'b1; wr_valid = 1'b1; wr_addr = 15'h0600; wr_data = 8'h5A;
      @(negedge clk);
      load_expire = 1'b0; wr_valid = 1'b0;
      chk("R11", "commit", int'(commit), 1);
      chk("R11", "protect", int'(protect), 0);
      wr(15'h0601, 8'h5B, 1, 0, "R11_same_load");
      expire(0, "R11");

      // R9: protected, partial key then a fresh load
      key("R9");
      expire(1, "R9_setup");
      wr(15'h5555, 8'hAA, 0, 1, "R9");
      wr(15'h2AAA, 8'h55, 0, 1, "R9");
      expire(1, "R9");
      wr(15'h5555, 8'hA0, 0, 0, "R9_fresh_protected");
      expire(1, "R9");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule